// File: doc/BRIEF.md
# Byte-Packing Transfer Buffer With Selectable Byte Order

This block sits between a host register port and a byte-serial bus transfer engine. It packs host writes into a four-byte store and hands bytes to the engine one at a time. In the other direction it collects bytes from the engine and returns them to the host in pairs. A host write is either a 16-bit word, which loads two bytes, or a single byte, which loads one and may only close a transfer. A byte-order input chooses which half of a 16-bit word lands in which lane, and the same choice applies when a word is read back.

The store is a 32-bit vector of four 8-bit lanes, with lane i in bits 8i+7..8i. Transmit and receive keep their own length counters over that shared store. On transmit the engine takes the byte in the highest filled lane, so the first byte written leaves first. On receive each byte is placed in the next free lane. Sticky flags report a pop from an empty transmit side, a push into a full receive side, and a read that found only one byte. Two ready flags tell the engine and the host when to act. All outputs are registered and take effect on the clock edge after the request. At most one request is served per cycle, in a fixed priority order.

Top module: `i2c_byte_buffer`

## Requirements
- R1: After a synchronous reset, both counts are 0, all five flags are 0, and eng_tx_byte and host_rdata are 0.
- R2: An accepted 16-bit write (host_wr=1, host_wr_byte=0) shifts the store up by two lanes, adds 2 to tx_count, and loads lanes 1 and 0. With order_hi=1, lane 1 gets host_wdata[15:8] and lane 0 gets host_wdata[7:0]. With order_hi=0, lane 1 gets host_wdata[7:0] and lane 0 gets host_wdata[15:8].
- R3: An accepted 8-bit write (host_wr_byte=1) shifts the store up by one lane, loads host_wdata[7:0] into lane 0, and adds 1 to tx_count. Every write after it is ignored until a pop brings tx_count back to 0.
- R4: A write is ignored when there is no room: a 16-bit write with tx_count above 2, an 8-bit write with tx_count of 4, or any write after an 8-bit write as in R3. The store and tx_count stay unchanged.
- R5: A pop with tx_count>0 first decrements tx_count, then puts the lane at the new count on eng_tx_byte in the next cycle. flag_tx_ready is set when the count reaches 0.
- R6: A pop with tx_count=0 sets flag_tx_underflow and leaves tx_count and eng_tx_byte unchanged. Every write request clears flag_tx_underflow and flag_tx_ready, whether or not the write is accepted.
- R7: A push with rx_count<4 stores eng_rx_byte in lane rx_count, adds 1 to rx_count, and sets flag_rx_ready. A push with rx_count=4 drops the byte and sets flag_rx_overrun.
- R8: A read with rx_count>=2 returns {lane1,lane0} when order_hi=1 and {lane0,lane1} when order_hi=0. The store then shifts down by two lanes and rx_count drops by 2.
- R9: A read with rx_count=1 returns {8'h00,lane0}, shifts the store down two lanes, sets rx_count to 0 and sets flag_single_byte. A read with rx_count=0 returns 0 and changes no count. Any read with rx_count other than 1 clears flag_single_byte.
- R10: Every read request clears flag_rx_ready and flag_rx_overrun.
- R11: At most one request is served per cycle, in the priority order write, read, pop, push. A request that loses has no effect at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| order_hi | input | 1 | Byte order select for 16-bit writes and reads |
| host_wr | input | 1 | Host data write request |
| host_wr_byte | input | 1 | With host_wr: 1 = 8-bit write, 0 = 16-bit write |
| host_wdata | input | 16 | Host write data |
| host_rd | input | 1 | Host data read request |
| host_rdata | output | 16 | Data from the last read |
| eng_pop | input | 1 | Engine takes one transmit byte |
| eng_tx_byte | output | 8 | Byte taken by the last pop |
| eng_push | input | 1 | Engine delivers one receive byte |
| eng_rx_byte | input | 8 | Byte delivered with eng_push |
| tx_count | output | 3 | Bytes waiting to be sent |
| rx_count | output | 3 | Bytes received and not yet read |
| flag_tx_underflow | output | 1 | Pop found the transmit side empty |
| flag_rx_overrun | output | 1 | Push found the receive side full |
| flag_single_byte | output | 1 | Last read found only one byte |
| flag_tx_ready | output | 1 | Transmit side drained, more data wanted |
| flag_rx_ready | output | 1 | A received byte is waiting |

## Verification
The bench goes after the two byte orders on both write and read. A swapped lane mapping would send or return bytes in reverse order. It also checks the closing 8-bit write that locks out later writes; a design without the lock would keep growing tx_count. Overflowing writes, popping an empty side and pushing a fifth byte are each driven, where a wrong design would wrap a count or lose a flag. Colliding requests are also driven, where a design that serves a losing request would move rx_count or tx_count at the wrong time.

// File: rtl/i2cbuf_pkg.sv
package i2cbuf_pkg;
  // Decoded operation for one cycle, after priority and room checks
  typedef enum logic [3:0] {
    OP_IDLE,
    OP_WR_PAIR,
    OP_WR_LAST,
    OP_WR_DROP,
    OP_READ,
    OP_POP,
    OP_POP_EMPTY,
    OP_PUSH,
    OP_PUSH_FULL
  } buf_op_e;
endpackage

// File: rtl/i2cbuf_arb.sv
module i2cbuf_arb
  import i2cbuf_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1)
) (
  input  logic          host_wr,
  input  logic          host_wr_byte,
  input  logic          host_rd,
  input  logic          eng_pop,
  input  logic          eng_push,
  input  logic [CW-1:0] tx_len,
  input  logic [CW-1:0] rx_len,
  input  logic          closed,
  output buf_op_e       op
);
  // Fixed priority: write, read, pop, push (R11)
  always_comb begin
    op = OP_IDLE;
    if (host_wr) begin
      if (closed)
        op = OP_WR_DROP;
      else if (!host_wr_byte && tx_len <= CW'(BYTES - 2))
        op = OP_WR_PAIR;
      else if (host_wr_byte && tx_len <= CW'(BYTES - 1))
        op = OP_WR_LAST;
      else
        op = OP_WR_DROP;
    end else if (host_rd) begin
      op = OP_READ;
    end else if (eng_pop) begin
      op = (tx_len == '0) ? OP_POP_EMPTY : OP_POP;
    end else if (eng_push) begin
      op = (rx_len == CW'(BYTES)) ? OP_PUSH_FULL : OP_PUSH;
    end
  end
endmodule

// File: rtl/i2cbuf_store.sv
module i2cbuf_store
  import i2cbuf_pkg::*;
#(
  parameter int BW    = 8,
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1),
  localparam int W    = BW * BYTES,
  localparam int HW   = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  buf_op_e       op,
  input  logic          order_hi,
  input  logic [HW-1:0] wdata,
  input  logic [BW-1:0] rx_byte,
  output logic [CW-1:0] tx_len,
  output logic [CW-1:0] rx_len,
  output logic          closed,
  output logic [BW-1:0] tx_byte,
  output logic [HW-1:0] rdata
);
  logic [W-1:0]  st, st_nx;
  logic [CW-1:0] tx_nx, rx_nx;
  logic          cl_nx;
  logic [BW-1:0] txb_nx;
  logic [HW-1:0] rd_nx;
  logic [HW-1:0] pair_in, pair_out;
  logic [BW-1:0] lane [BYTES];

  // Lane view of the flat store
  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane[g] = st[g*BW +: BW];
  end

  // Byte order mapping between the host word and lanes 1/0
  assign pair_in  = order_hi ? wdata : {wdata[BW-1:0], wdata[HW-1:BW]};
  assign pair_out = order_hi ? {lane[1], lane[0]} : {lane[0], lane[1]};

  always_comb begin
    st_nx  = st;
    tx_nx  = tx_len;
    rx_nx  = rx_len;
    cl_nx  = closed;
    txb_nx = tx_byte;
    rd_nx  = rdata;
    unique case (op)
      OP_WR_PAIR: begin
        st_nx = {st[W-HW-1:0], pair_in};
        tx_nx = tx_len + CW'(2);
      end
      OP_WR_LAST: begin
        st_nx = {st[W-BW-1:0], wdata[BW-1:0]};
        tx_nx = tx_len + CW'(1);
        cl_nx = 1'b1;
      end
      OP_READ: begin
        if (rx_len >= CW'(2)) begin
          rd_nx = pair_out;
          st_nx = {{HW{1'b0}}, st[W-1:HW]};
          rx_nx = rx_len - CW'(2);
        end else if (rx_len == CW'(1)) begin
          rd_nx = {{BW{1'b0}}, lane[0]};
          st_nx = {{HW{1'b0}}, st[W-1:HW]};
          rx_nx = '0;
        end else begin
          rd_nx = '0;
        end
      end
      OP_POP: begin
        tx_nx = tx_len - CW'(1);
        for (int i = 0; i < BYTES; i++)
          if (CW'(i) == tx_len - CW'(1)) txb_nx = lane[i];
        if (tx_len == CW'(1)) cl_nx = 1'b0;
      end
      OP_PUSH: begin
        for (int i = 0; i < BYTES; i++)
          if (CW'(i) == rx_len) st_nx[i*BW +: BW] = rx_byte;
        rx_nx = rx_len + CW'(1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= '0;
      tx_len  <= '0;
      rx_len  <= '0;
      closed  <= 1'b0;
      tx_byte <= '0;
      rdata   <= '0;
    end else begin
      st      <= st_nx;
      tx_len  <= tx_nx;
      rx_len  <= rx_nx;
      closed  <= cl_nx;
      tx_byte <= txb_nx;
      rdata   <= rd_nx;
    end
  end

  // R5: transmit count never exceeds the store size
  p_tx_bound_r5: assert property (@(posedge clk) disable iff (rst)
    tx_len <= CW'(BYTES));
  // R7: receive count never exceeds the store size
  p_rx_bound_r7: assert property (@(posedge clk) disable iff (rst)
    rx_len <= CW'(BYTES));
  // R7: a full receive side keeps its count on a push
  p_push_full_keep_r7: assert property (@(posedge clk) disable iff (rst)
    op == OP_PUSH_FULL |=> $stable(rx_len));
  // R4: an ignored write touches neither store nor count
  p_drop_keeps_r4: assert property (@(posedge clk) disable iff (rst)
    op == OP_WR_DROP |=> $stable(tx_len) && $stable(st));
  // R3: a byte write locks out later writes
  p_last_closes_r3: assert property (@(posedge clk) disable iff (rst)
    op == OP_WR_LAST |=> closed);
  // R8: a paired read takes two bytes
  p_read_pair_r8: assert property (@(posedge clk) disable iff (rst)
    op == OP_READ && rx_len >= CW'(2) |=> rx_len == $past(rx_len) - CW'(2));
endmodule

// File: rtl/i2cbuf_flags.sv
module i2cbuf_flags
  import i2cbuf_pkg::*;
#(
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  buf_op_e       op,
  input  logic [CW-1:0] tx_len,
  input  logic [CW-1:0] rx_len,
  output logic          udf,
  output logic          ovr,
  output logic          single,
  output logic          xrdy,
  output logic          rrdy
);
  logic is_wr;
  assign is_wr = (op == OP_WR_PAIR) || (op == OP_WR_LAST) || (op == OP_WR_DROP);

  always_ff @(posedge clk) begin
    if (rst) begin
      udf    <= 1'b0;
      ovr    <= 1'b0;
      single <= 1'b0;
      xrdy   <= 1'b0;
      rrdy   <= 1'b0;
    end else begin
      if (is_wr) begin
        udf  <= 1'b0;
        xrdy <= 1'b0;
      end
      if (op == OP_POP_EMPTY) udf <= 1'b1;
      if (op == OP_POP && tx_len == CW'(1)) xrdy <= 1'b1;
      if (op == OP_PUSH) rrdy <= 1'b1;
      if (op == OP_PUSH_FULL) ovr <= 1'b1;
      if (op == OP_READ) begin
        rrdy   <= 1'b0;
        ovr    <= 1'b0;
        single <= (rx_len == CW'(1));
      end
    end
  end

  // R6: popping an empty side raises underflow
  p_udf_set_r6: assert property (@(posedge clk) disable iff (rst)
    op == OP_POP_EMPTY |=> udf);
  // R6: any write request clears underflow and transmit ready
  p_wr_clear_r6: assert property (@(posedge clk) disable iff (rst)
    is_wr |=> !udf && !xrdy);
  // R10: any read clears receive ready and overrun
  p_rd_clear_r10: assert property (@(posedge clk) disable iff (rst)
    op == OP_READ |=> !rrdy && !ovr);
  // R9: a lone-byte read raises the single-byte flag
  p_single_r9: assert property (@(posedge clk) disable iff (rst)
    op == OP_READ && rx_len == CW'(1) |=> single);
endmodule

// File: rtl/i2c_byte_buffer.sv
module i2c_byte_buffer
  import i2cbuf_pkg::*;
#(
  parameter int BW    = 8,
  parameter int BYTES = 4,
  localparam int CW   = $clog2(BYTES + 1),
  localparam int HW   = 2 * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          order_hi,
  input  logic          host_wr,
  input  logic          host_wr_byte,
  input  logic [HW-1:0] host_wdata,
  input  logic          host_rd,
  output logic [HW-1:0] host_rdata,
  input  logic          eng_pop,
  output logic [BW-1:0] eng_tx_byte,
  input  logic          eng_push,
  input  logic [BW-1:0] eng_rx_byte,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  output logic          flag_tx_underflow,
  output logic          flag_rx_overrun,
  output logic          flag_single_byte,
  output logic          flag_tx_ready,
  output logic          flag_rx_ready
);
  buf_op_e op;
  logic    closed;

  i2cbuf_arb #(.BYTES(BYTES)) u_arb (
    .host_wr      (host_wr),
    .host_wr_byte (host_wr_byte),
    .host_rd      (host_rd),
    .eng_pop      (eng_pop),
    .eng_push     (eng_push),
    .tx_len       (tx_count),
    .rx_len       (rx_count),
    .closed       (closed),
    .op           (op)
  );

  i2cbuf_store #(.BW(BW), .BYTES(BYTES)) u_store (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .order_hi (order_hi),
    .wdata    (host_wdata),
    .rx_byte  (eng_rx_byte),
    .tx_len   (tx_count),
    .rx_len   (rx_count),
    .closed   (closed),
    .tx_byte  (eng_tx_byte),
    .rdata    (host_rdata)
  );

  i2cbuf_flags #(.BYTES(BYTES)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .op     (op),
    .tx_len (tx_count),
    .rx_len (rx_count),
    .udf    (flag_tx_underflow),
    .ovr    (flag_rx_overrun),
    .single (flag_single_byte),
    .xrdy   (flag_tx_ready),
    .rrdy   (flag_rx_ready)
  );

  // R11: a write request shadows read and push, so the receive count holds
  p_write_wins_r11: assert property (@(posedge clk) disable iff (rst)
    host_wr |=> $stable(rx_count));
  // R11: a read shadows pop, so the transmit count holds
  p_read_wins_r11: assert property (@(posedge clk) disable iff (rst)
    !host_wr && host_rd |=> $stable(tx_count));
endmodule

// File: tb/tb_i2c_byte_buffer.sv
module tb_i2c_byte_buffer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        order_hi = 1'b1;
  logic        host_wr = 1'b0, host_wr_byte = 1'b0, host_rd = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        eng_pop = 1'b0, eng_push = 1'b0;
  logic [7:0]  eng_rx_byte = '0;
  logic [7:0]  eng_tx_byte;
  logic [2:0]  tx_count, rx_count;
  logic        flag_tx_underflow, flag_rx_overrun, flag_single_byte;
  logic        flag_tx_ready, flag_rx_ready;

  int checks = 0;
  int errors = 0;

  // Reference model state
  logic [31:0] m_st;
  int          m_tx, m_rx;
  bit          m_closed, m_udf, m_ovr, m_single, m_xrdy, m_rrdy;
  logic [7:0]  m_txb;
  logic [15:0] m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_byte_buffer dut (
    .clk(clk), .rst(rst), .order_hi(order_hi),
    .host_wr(host_wr), .host_wr_byte(host_wr_byte), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_pop(eng_pop), .eng_tx_byte(eng_tx_byte),
    .eng_push(eng_push), .eng_rx_byte(eng_rx_byte),
    .tx_count(tx_count), .rx_count(rx_count),
    .flag_tx_underflow(flag_tx_underflow), .flag_rx_overrun(flag_rx_overrun),
    .flag_single_byte(flag_single_byte), .flag_tx_ready(flag_tx_ready),
    .flag_rx_ready(flag_rx_ready)
  );

  function automatic logic [15:0] lanes_for_write(logic [15:0] wd, bit ord);
    return ord ? wd : {wd[7:0], wd[15:8]};
  endfunction

  function automatic logic [15:0] word_for_read(logic [31:0] st, bit ord);
    return ord ? st[15:0] : {st[7:0], st[15:8]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string tag, string ftag);
    chk(tag,  "tx_count",    int'(tx_count),    m_tx);
    chk(tag,  "rx_count",    int'(rx_count),    m_rx);
    chk(tag,  "eng_tx_byte", int'(eng_tx_byte), int'(m_txb));
    chk(tag,  "host_rdata",  int'(host_rdata),  int'(m_rd));
    chk(ftag, "underflow",   int'(flag_tx_underflow), int'(m_udf));
    chk(ftag, "overrun",     int'(flag_rx_overrun),   int'(m_ovr));
    chk(ftag, "single",      int'(flag_single_byte),  int'(m_single));
    chk(ftag, "tx_ready",    int'(flag_tx_ready),     int'(m_xrdy));
    chk(ftag, "rx_ready",    int'(flag_rx_ready),     int'(m_rrdy));
  endtask

  task automatic model_reset();
    m_st = '0; m_tx = 0; m_rx = 0; m_closed = 0;
    m_udf = 0; m_ovr = 0; m_single = 0; m_xrdy = 0; m_rrdy = 0;
    m_txb = '0; m_rd = '0;
  endtask

  // One request cycle; called at a falling edge, returns at the next one
  task automatic step(input bit wr, input bit wb, input bit rd, input bit pp,
                      input bit ps, input logic [15:0] wd, input logic [7:0] rb,
                      input bit ord);
    string tag, ftag;
    int n;
    n = int'(wr) + int'(rd) + int'(pp) + int'(ps);
    order_hi = ord; host_wr = wr; host_wr_byte = wb; host_rd = rd;
    eng_pop = pp; eng_push = ps; host_wdata = wd; eng_rx_byte = rb;
    @(negedge clk);
    host_wr = 0; host_rd = 0; eng_pop = 0; eng_push = 0;
    tag = "R11";
    ftag = "R11";
    if (wr) begin
      m_udf = 0; m_xrdy = 0;
      if (!wb && !m_closed && m_tx <= 2) begin
        m_st = {m_st[15:0], lanes_for_write(wd, ord)}; m_tx += 2; tag = "R2";
      end else if (wb && !m_closed && m_tx <= 3) begin
        m_st = {m_st[23:0], wd[7:0]}; m_tx += 1; m_closed = 1; tag = "R3";
      end else tag = "R4";
      ftag = "R6";
    end else if (rd) begin
      m_rrdy = 0; m_ovr = 0;
      if (m_rx >= 2) begin
        m_rd = word_for_read(m_st, ord); m_st = m_st >> 16; m_rx -= 2;
        m_single = 0; tag = "R8";
      end else if (m_rx == 1) begin
        m_rd = {8'h00, m_st[7:0]}; m_st = m_st >> 16; m_rx = 0;
        m_single = 1; tag = "R9";
      end else begin
        m_rd = '0; m_single = 0; tag = "R9";
      end
      ftag = "R10";
    end else if (pp) begin
      if (m_tx == 0) begin
        m_udf = 1; tag = "R6";
      end else begin
        m_tx -= 1; m_txb = m_st[m_tx*8 +: 8];
        if (m_tx == 0) begin m_xrdy = 1; m_closed = 0; end
        tag = "R5";
      end
      ftag = tag;
    end else if (ps) begin
      if (m_rx == 4) m_ovr = 1;
      else begin m_st[m_rx*8 +: 8] = rb; m_rx += 1; m_rrdy = 1; end
      tag = "R7";
      ftag = "R7";
    end
    if (n > 1) begin tag = "R11"; ftag = "R11"; end
    compare_all(tag, ftag);
  endtask

  task automatic do_wr(logic [15:0] wd, bit wb, bit ord);
    step(1, wb, 0, 0, 0, wd, 8'h00, ord);
  endtask
  task automatic do_rd(bit ord);
    step(0, 0, 1, 0, 0, 16'h0000, 8'h00, ord);
  endtask
  task automatic do_pop();
    step(0, 0, 0, 1, 0, 16'h0000, 8'h00, 1);
  endtask
  task automatic do_push(logic [7:0] b);
    step(0, 0, 0, 0, 1, 16'h0000, b, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd24681));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset state
    compare_all("R1", "R1");

    // R2: high order, first popped byte is host_wdata[15:8]
    do_wr(16'hA1B2, 0, 1);
    do_pop();
    chk("R2", "first byte high order", int'(eng_tx_byte), 'hA1);
    do_pop();
    chk("R2", "second byte high order", int'(eng_tx_byte), 'hB2);
    // R2: low order swaps the lanes
    do_wr(16'hA1B2, 0, 0);
    do_pop();
    chk("R2", "first byte low order", int'(eng_tx_byte), 'hB2);
    do_pop();
    // R6: pop on empty side, then write request clears
    do_pop();
    do_pop();
    do_wr(16'h1234, 0, 1);
    // R3/R4: closing byte write then later writes are dropped
    do_wr(16'h0055, 1, 1);
    do_wr(16'h7777, 0, 1);
    do_wr(16'h0066, 1, 1);
    repeat (4) do_pop();
    // R4: fill to four, then overflowing writes
    do_wr(16'h0102, 0, 1);
    do_wr(16'h0304, 0, 1);
    do_wr(16'h0506, 0, 1);
    do_wr(16'h0007, 1, 1);
    repeat (5) do_pop();
    // R7: five pushes, last overruns; R8 both orders; R10 clearing
    do_push(8'h11); do_push(8'h22); do_push(8'h33); do_push(8'h44); do_push(8'h55);
    do_rd(1);
    chk("R8", "word high order", int'(host_rdata), 'h2211);
    do_rd(0);
    chk("R8", "word low order", int'(host_rdata), 'h3344);
    do_rd(1);
    // R9: lone byte read
    do_push(8'h9C);
    do_rd(1);
    chk("R9", "lone byte", int'(host_rdata), 'h009C);
    do_rd(1);
    // R11: collisions
    do_push(8'hAB);
    step(1, 0, 1, 1, 1, 16'hCAFE, 8'hEE, 1);
    step(0, 0, 1, 1, 1, 16'h0000, 8'hEE, 1);
    step(0, 0, 0, 1, 1, 16'h0000, 8'hEE, 1);

    // Constrained random mix
    for (int k = 0; k < 1500; k++) begin
      int r;
      bit ord;
      r = int'($urandom % 16);
      ord = bit'($urandom % 2);
      if (r < 3)       do_wr(16'($urandom), 0, ord);
      else if (r < 4)  do_wr(16'($urandom), 1, ord);
      else if (r < 7)  do_rd(ord);
      else if (r < 10) do_pop();
      else if (r < 14) do_push(8'($urandom));
      else             step(bit'($urandom % 2), bit'($urandom % 2), bit'($urandom % 2),
                            bit'($urandom % 2), bit'($urandom % 2), 16'($urandom),
                            8'($urandom), ord);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule